// File: doc/BRIEF.md
# Dual-Link Video Line Splitter

The splitter sits between a single raster source and two display links. It receives one pixel per clock with a valid qualifier, a data-enable and the two sync signals. It copies two windows of each active line to two output ports. The left window always begins at pixel 0. The right window begins at a programmable start pixel. The two windows may have different lengths and may overlap. Pixels inside an overlap are sent on both ports. A swap bit chooses which window goes to which port.

Each port owns a line buffer. Both ports start reading out in the same cycle. That cycle is fixed by the arrival of the right window's first pixel, so the two output lines begin together. The configuration inputs are captured only on a rising vsync. Every line of a frame therefore uses one setting. If an input line ends before a window is complete, the port carrying that window reports an error pulse and sends only what it received.

Top module: `dls_top`

## Requirements
- R1: With the swap bit at 0, port 0 sends pixels 0 to LEN_L-1 of each line and port 1 sends pixels START_R to START_R+LEN_R-1, each in input order. out_data holds port 0 in bits [DW-1:0] and port 1 in bits [2*DW-1:DW].
- R2: With the swap bit at 1, port 0 sends the right window and port 1 sends the left window.
- R3: When START_R is below LEN_L, the pixels from START_R to LEN_L-1 appear on both ports.
- R4: LEN_L and LEN_R are independent. Each port sends exactly its own window's length, in contiguous cycles when the input has no gaps.
- R5: Let T be the cycle in which input pixel START_R is accepted. Both ports raise out_hsync for exactly one cycle, T+1. Each port's first pixel appears at T+2, so the line-start skew between the ports is zero.
- R6: out_de is high only while window pixels are output. It drops in the cycle after the last pixel, and it is never high together with out_hsync.
- R7: The configuration inputs (cfg_len_l, cfg_start_r, cfg_len_r, cfg_swap) take effect only in the cycle after a rising edge of in_vsync. Changes made at any other time have no effect on the output.
- R8: A line ends on the first cycle after its pixels with in_hsync high, or with in_valid high and in_de low. Suppose the count of pixels received is below a window's end (its start plus its length). The port carrying that window then pulses out_err for one cycle, one cycle after the line end, and sends only the pixels it received. If the line never reaches START_R, neither port outputs anything for that line.
- R9: During and after reset all outputs are 0. Until the first vsync, the active setting is LEN_L = START_R = LEN_R = MAX_SEG with no swap.
- R10: A pixel is accepted only when in_valid and in_de are both high. Idle cycles inside a line delay the output but never reorder, drop or duplicate pixels.
- R11: A window may be MAX_SEG pixels long (default 2048). With LEN_L = START_R = LEN_R = MAX_SEG, both ports send complete windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_l | input | 12 | Left window length (LW bits) |
| cfg_start_r | input | 12 | First pixel of the right window |
| cfg_len_r | input | 12 | Right window length |
| cfg_swap | input | 1 | 0: port 0 left, port 1 right; 1: exchanged |
| in_valid | input | 1 | Input beat qualifier |
| in_hsync | input | 1 | Input horizontal sync |
| in_vsync | input | 1 | Input vertical sync; rising edge loads the configuration |
| in_de | input | 1 | Input data enable |
| in_data | input | 24 | Input pixel |
| out_hsync | output | 2 | Per-port line-start pulse |
| out_de | output | 2 | Per-port data enable |
| out_data | output | 48 | Per-port pixel, port p in bits [p*DW +: DW] |
| out_err | output | 2 | Per-port short-line error pulse |

## Verification
The bench targets overlapping windows, a swapped mapping, unequal lengths, gapped input and windows of the full 2048 pixels. A wrong overlap test would drop the shared pixels from one port. A full-length window would expose a buffer pointer or counter that is one bit too narrow, as wrapped or repeated data. Short lines are driven in two forms. In the first, the right window has started. A design that forgot to truncate would then stall and later leak the next line's pixels into the old one. In the second, the right window never starts. A design that failed to discard the buffered left pixels would emit them with the following line. A configuration change in mid-frame checks that the output ignores the new value until vsync.

// File: rtl/dls_pkg.sv
package dls_pkg;

    localparam int NPORT = 2;

    typedef enum logic {
        SEG_LEFT  = 1'b0,
        SEG_RIGHT = 1'b1
    } seg_e;

    // Which window a port carries: port 0 is left unless swapped.
    function automatic seg_e port_seg(input int port, input logic swap);
        return seg_e'((port == 1) ^ swap);
    endfunction

endpackage

// File: rtl/dls_cfg.sv
module dls_cfg
    import dls_pkg::*;
#(
    parameter int MAX_SEG = 2048,
    parameter int LW      = 12,
    parameter int CW      = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_vsync,
    input  logic [LW-1:0]              cfg_len_l,
    input  logic [LW-1:0]              cfg_start_r,
    input  logic [LW-1:0]              cfg_len_r,
    input  logic                       cfg_swap,
    output logic [CW-1:0]              act_start,
    output logic [NPORT-1:0][CW-1:0]   seg_lo,
    output logic [NPORT-1:0][CW-1:0]   seg_hi,
    output logic [NPORT-1:0][CW-1:0]   seg_len
);

    typedef struct packed {
        logic          vs;
        logic [LW-1:0] len_l;
        logic [LW-1:0] start_r;
        logic [LW-1:0] len_r;
        logic          swap;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        cfg_d.vs = in_vsync;
        // Shadow copy is refreshed only on the vsync rising edge.
        if (in_vsync && !cfg_q.vs) begin
            cfg_d.len_l   = cfg_len_l;
            cfg_d.start_r = cfg_start_r;
            cfg_d.len_r   = cfg_len_r;
            cfg_d.swap    = cfg_swap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.vs      <= 1'b0;
            cfg_q.len_l   <= LW'(MAX_SEG);
            cfg_q.start_r <= LW'(MAX_SEG);
            cfg_q.len_r   <= LW'(MAX_SEG);
            cfg_q.swap    <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign act_start = CW'(cfg_q.start_r);

    for (genvar p = 0; p < NPORT; p++) begin : g_route
        always_comb begin
            if (port_seg(p, cfg_q.swap) == SEG_RIGHT) begin
                seg_lo[p]  = CW'(cfg_q.start_r);
                seg_len[p] = CW'(cfg_q.len_r);
            end else begin
                seg_lo[p]  = '0;
                seg_len[p] = CW'(cfg_q.len_l);
            end
            seg_hi[p] = seg_lo[p] + seg_len[p];
        end
    end

endmodule

// File: rtl/dls_ctrl.sv
module dls_ctrl #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_de,
    input  logic          in_hsync,
    input  logic [CW-1:0] act_start,
    output logic          pix,
    output logic [CW-1:0] idx,
    output logic          line_end,
    output logic          launch,
    output logic          launched
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          inl;
        logic          lch;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        pix      = in_valid & in_de;
        line_end = st_q.inl & ~pix & (in_hsync | in_valid);
        launch   = pix & ~st_q.lch & (st_q.cnt == act_start);

        st_d = st_q;
        if (pix) begin
            st_d.cnt = st_q.cnt + CW'(1);
            st_d.inl = 1'b1;
        end
        if (launch) begin
            st_d.lch = 1'b1;
        end
        if (line_end) begin
            st_d.cnt = '0;
            st_d.inl = 1'b0;
            st_d.lch = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx      = st_q.cnt;
    assign launched = st_q.lch;

endmodule

// File: rtl/dls_port.sv
module dls_port #(
    parameter int DW    = 24,
    parameter int CW    = 13,
    parameter int DEPTH = 2048
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix,
    input  logic [CW-1:0] idx,
    input  logic [DW-1:0] in_data,
    input  logic          line_end,
    input  logic          launch,
    input  logic          launched,
    input  logic [CW-1:0] seg_lo,
    input  logic [CW-1:0] seg_hi,
    input  logic [CW-1:0] seg_len,
    output logic          out_hsync,
    output logic          out_de,
    output logic [DW-1:0] out_data,
    output logic          out_err
);

    localparam int AW = $clog2(DEPTH);
    localparam int OW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [OW-1:0] occ;
        logic [CW-1:0] rem;
        logic [OW-1:0] lwc;
        logic          hs;
        logic          de;
        logic [DW-1:0] data;
        logic          err;
    } port_t;

    port_t st_d, st_q;
    logic [DW-1:0] mem [DEPTH];

    logic          wr;
    logic          pop;
    logic          short_seg;
    logic [OW-1:0] occ_a;
    logic [CW-1:0] rem_a;

    always_comb begin
        wr        = pix && (idx >= seg_lo) && (idx < seg_hi);
        pop       = (st_q.rem != '0) && (st_q.occ != '0);
        short_seg = idx < seg_hi;
        occ_a     = st_q.occ + OW'(wr) - OW'(pop);
        rem_a     = st_q.rem - CW'(pop);

        st_d      = st_q;
        st_d.hs   = launch;
        st_d.de   = pop;
        st_d.err  = 1'b0;
        st_d.data = pop ? mem[st_q.rp] : '0;
        st_d.occ  = occ_a;
        st_d.rem  = rem_a;

        if (wr) begin
            st_d.wp  = st_q.wp + AW'(1);
            st_d.lwc = st_q.lwc + OW'(1);
        end
        if (pop) begin
            st_d.rp = st_q.rp + AW'(1);
        end
        // Release this line's window for readout; earlier lines stay queued.
        if (launch) begin
            st_d.rem = rem_a + seg_len;
        end
        if (line_end) begin
            st_d.lwc = '0;
            st_d.err = short_seg;
            if (!launched) begin
                // Line never reached the right window: discard this line's pixels.
                st_d.wp  = st_q.wp - st_q.lwc[AW-1:0];
                st_d.occ = occ_a - st_q.lwc;
            end else if (short_seg) begin
                // Truncated window: only what is queued will be sent.
                st_d.rem = CW'(occ_a);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[st_q.wp] <= in_data;
        end
    end

    assign out_hsync = st_q.hs;
    assign out_de    = st_q.de;
    assign out_data  = st_q.data;
    assign out_err   = st_q.err;

endmodule

// File: rtl/dls_top.sv
module dls_top
    import dls_pkg::*;
#(
    parameter int DW      = 24,
    parameter int MAX_SEG = 2048
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(MAX_SEG):0]      cfg_len_l,
    input  logic [$clog2(MAX_SEG):0]      cfg_start_r,
    input  logic [$clog2(MAX_SEG):0]      cfg_len_r,
    input  logic                          cfg_swap,
    input  logic                          in_valid,
    input  logic                          in_hsync,
    input  logic                          in_vsync,
    input  logic                          in_de,
    input  logic [DW-1:0]                 in_data,
    output logic [1:0]                    out_hsync,
    output logic [1:0]                    out_de,
    output logic [2*DW-1:0]               out_data,
    output logic [1:0]                    out_err
);

    localparam int LW    = $clog2(MAX_SEG) + 1;
    localparam int CW    = LW + 1;
    localparam int DEPTH = MAX_SEG;

    logic [CW-1:0]            act_start;
    logic [NPORT-1:0][CW-1:0] seg_lo;
    logic [NPORT-1:0][CW-1:0] seg_hi;
    logic [NPORT-1:0][CW-1:0] seg_len;
    logic                     pix;
    logic [CW-1:0]            idx;
    logic                     line_end;
    logic                     launch;
    logic                     launched;

    dls_cfg #(.MAX_SEG(MAX_SEG), .LW(LW), .CW(CW)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vsync   (in_vsync),
        .cfg_len_l  (cfg_len_l),
        .cfg_start_r(cfg_start_r),
        .cfg_len_r  (cfg_len_r),
        .cfg_swap   (cfg_swap),
        .act_start  (act_start),
        .seg_lo     (seg_lo),
        .seg_hi     (seg_hi),
        .seg_len    (seg_len)
    );

    dls_ctrl #(.CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_de    (in_de),
        .in_hsync (in_hsync),
        .act_start(act_start),
        .pix      (pix),
        .idx      (idx),
        .line_end (line_end),
        .launch   (launch),
        .launched (launched)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dls_port #(.DW(DW), .CW(CW), .DEPTH(DEPTH)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .pix      (pix),
            .idx      (idx),
            .in_data  (in_data),
            .line_end (line_end),
            .launch   (launch),
            .launched (launched),
            .seg_lo   (seg_lo[p]),
            .seg_hi   (seg_hi[p]),
            .seg_len  (seg_len[p]),
            .out_hsync(out_hsync[p]),
            .out_de   (out_de[p]),
            .out_data (out_data[p*DW +: DW]),
            .out_err  (out_err[p])
        );
    end

endmodule

// File: rtl/dls_chk.sv
module dls_chk #(
    parameter int CW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_vsync,
    input logic [1:0]    out_hsync,
    input logic [1:0]    out_de,
    input logic [1:0]    out_err,
    input logic          line_end,
    input logic [CW-1:0] act_start
);

    logic vs_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vs_prev <= 1'b0;
        else        vs_prev <= in_vsync;
    end
    logic vs_rise;
    assign vs_rise = in_vsync & ~vs_prev;

    // R5
    hsync_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hsync[0] == out_hsync[1]);

    // R5
    hsync_lead0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hsync[0] |=> out_de[0]);

    // R5
    hsync_lead1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hsync[1] |=> out_de[1]);

    // R6
    hs_de_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hsync & out_de) == 2'b00);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_err != 2'b00) |-> $past(line_end));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(vs_rise) |-> $stable(act_start));

endmodule

bind dls_top dls_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vsync (in_vsync),
    .out_hsync(out_hsync),
    .out_de   (out_de),
    .out_err  (out_err),
    .line_end (line_end),
    .act_start(act_start)
);

// File: tb/dls_top_test.sv
module dls_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 24;
    localparam int MAX_SEG    = 2048;
    localparam int LW         = $clog2(MAX_SEG) + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LW-1:0]     cfg_len_l = '0;
    logic [LW-1:0]     cfg_start_r = '0;
    logic [LW-1:0]     cfg_len_r = '0;
    logic              cfg_swap = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_hsync = 1'b0;
    logic              in_vsync = 1'b0;
    logic              in_de = 1'b0;
    logic [DW-1:0]     in_data = '0;
    logic [1:0]        out_hsync;
    logic [1:0]        out_de;
    logic [2*DW-1:0]   out_data;
    logic [1:0]        out_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dls_top #(.DW(DW), .MAX_SEG(MAX_SEG)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_len_l(cfg_len_l), .cfg_start_r(cfg_start_r), .cfg_len_r(cfg_len_r), .cfg_swap(cfg_swap),
        .in_valid(in_valid), .in_hsync(in_hsync), .in_vsync(in_vsync), .in_de(in_de), .in_data(in_data),
        .out_hsync(out_hsync), .out_de(out_de), .out_data(out_data), .out_err(out_err)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string tag = "R1";
    int    lnum = 0;
    int    cyc = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_len_l, m_start, m_len_r, m_swap, m_vs;
    int m_cnt, m_inl, m_lch;
    int mq [2][$];
    int m_rem [2];
    int m_lwc [2];
    int e_hs [2], e_de [2], e_data [2], e_err [2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_len_l = MAX_SEG; m_start = MAX_SEG; m_len_r = MAX_SEG; m_swap = 0; m_vs = 0;
            m_cnt = 0; m_inl = 0; m_lch = 0;
            for (int p = 0; p < 2; p++) begin
                mq[p].delete(); m_rem[p] = 0; m_lwc[p] = 0;
                e_hs[p] = 0; e_de[p] = 0; e_data[p] = 0; e_err[p] = 0;
            end
        end else begin
            bit pix, le, lau;
            pix = in_valid && in_de;
            le  = m_inl != 0 && !pix && (in_hsync || in_valid);
            lau = pix && m_lch == 0 && m_cnt == m_start;
            for (int p = 0; p < 2; p++) begin
                int lo, ln;
                bit right;
                right = ((p == 1) ? 1 : 0) ^ m_swap;
                lo = right ? m_start : 0;
                ln = right ? m_len_r : m_len_l;
                e_hs[p] = lau; e_err[p] = 0; e_de[p] = 0; e_data[p] = 0;
                if (m_rem[p] > 0 && mq[p].size() > 0) begin
                    e_de[p] = 1; e_data[p] = mq[p].pop_front(); m_rem[p]--;
                end
                if (pix && m_cnt >= lo && m_cnt < lo + ln) begin
                    mq[p].push_back(int'(in_data)); m_lwc[p]++;
                end
                if (lau) m_rem[p] += ln;
                if (le) begin
                    e_err[p] = (m_cnt < lo + ln);
                    if (m_lch == 0) begin
                        for (int k = 0; k < m_lwc[p]; k++) void'(mq[p].pop_back());
                    end else if (e_err[p] != 0) begin
                        m_rem[p] = mq[p].size();
                    end
                    m_lwc[p] = 0;
                end
            end
            if (pix) begin m_cnt++; m_inl = 1; end
            if (lau) m_lch = 1;
            if (le) begin m_cnt = 0; m_inl = 0; m_lch = 0; end
            if (in_vsync && m_vs == 0) begin
                m_len_l = cfg_len_l; m_start = cfg_start_r; m_len_r = cfg_len_r; m_swap = cfg_swap;
            end
            m_vs = in_vsync;
        end
    end

    // Per-line observations
    int de_cnt [2], first [2], hs_at [2], err_seen [2];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int p = 0; p < 2; p++) begin
                check("R5", $sformatf("port%0d hsync", p), out_hsync[p], e_hs[p]);
                check("R6", $sformatf("port%0d de", p), out_de[p], e_de[p]);
                check("R8", $sformatf("port%0d err", p), out_err[p], e_err[p]);
                if (e_de[p] != 0)
                    check(tag, $sformatf("port%0d data", p), out_data[p*DW +: DW], e_data[p]);
                if (out_de[p]) begin
                    if (de_cnt[p] == 0) first[p] = int'(out_data[p*DW +: DW]);
                    de_cnt[p]++;
                end
                if (out_hsync[p]) hs_at[p] = cyc;
                if (out_err[p]) err_seen[p] = 1;
            end
        end
    end

    task automatic new_frame(input int ll, input int sr, input int lr, input int sw);
        @(negedge clk);
        cfg_len_l = LW'(ll); cfg_start_r = LW'(sr); cfg_len_r = LW'(lr); cfg_swap = sw[0];
        in_valid = 1'b1; in_de = 1'b0; in_vsync = 1'b1;
        repeat (2) @(negedge clk);
        in_vsync = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_line(input int n, input int gap);
        for (int p = 0; p < 2; p++) begin
            de_cnt[p] = 0; first[p] = -1; hs_at[p] = -1; err_seen[p] = 0;
        end
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % gap) == gap - 1) begin
                in_valid = 1'b0; in_de = 1'b1;
                @(negedge clk);
            end
            in_valid = 1'b1; in_de = 1'b1; in_hsync = 1'b0;
            in_data = DW'((lnum << 12) | i);
            @(negedge clk);
        end
        in_de = 1'b0; in_valid = 1'b1;
        for (int b = 0; b < n + 40; b++) begin
            in_hsync = (b == 8);
            @(negedge clk);
        end
        in_hsync = 1'b0;
    endtask

    function automatic int seg_cnt(input int n, input int lo, input int ln, input int st);
        int a;
        if (n <= st) return 0;
        a = n - lo;
        if (a < 0) a = 0;
        return (a < ln) ? a : ln;
    endfunction

    // Independent per-line check computed from window arithmetic only.
    task automatic check_line(input string req, input int n, input int st,
                              input int lo0, input int ln0, input int lo1, input int ln1);
        int c0, c1;
        c0 = seg_cnt(n, lo0, ln0, st);
        c1 = seg_cnt(n, lo1, ln1, st);
        check(req, "port0 pixel count", de_cnt[0], c0);
        check(req, "port1 pixel count", de_cnt[1], c1);
        if (c0 > 0) check(req, "port0 first pixel", first[0], (lnum << 12) | lo0);
        if (c1 > 0) check(req, "port1 first pixel", first[1], (lnum << 12) | lo1);
        if (c0 > 0 && c1 > 0) check("R5", "hsync skew", hs_at[0], hs_at[1]);
        check("R8", "port0 error", err_seen[0], (n < lo0 + ln0) ? 1 : 0);
        check("R8", "port1 error", err_seen[1], (n < lo1 + ln1) ? 1 : 0);
        lnum++;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", "hsync in reset", out_hsync, 0);
        check("R9", "de in reset", out_de, 0);
        check("R9", "err in reset", out_err, 0);
        check("R9", "data in reset", out_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        tag = "R1";
        new_frame(16, 16, 16, 0);
        run_line(32, 0); check_line("R1", 32, 16, 0, 16, 16, 16);
        run_line(32, 0); check_line("R1", 32, 16, 0, 16, 16, 16);

        tag = "R3";
        new_frame(20, 12, 20, 0);
        run_line(32, 0); check_line("R3", 32, 12, 0, 20, 12, 20);

        tag = "R4";
        new_frame(10, 10, 25, 0);
        run_line(35, 0); check_line("R4", 35, 10, 0, 10, 10, 25);

        tag = "R2";
        new_frame(10, 10, 25, 1);
        run_line(35, 0); check_line("R2", 35, 10, 10, 25, 0, 10);

        tag = "R7";
        @(negedge clk);
        cfg_len_l = 5; cfg_start_r = 3; cfg_len_r = 7; cfg_swap = 1'b0;
        run_line(35, 0); check_line("R7", 35, 10, 10, 25, 0, 10);
        new_frame(5, 3, 7, 0);
        run_line(35, 0); check_line("R7", 35, 3, 0, 5, 3, 7);

        tag = "R10";
        new_frame(16, 16, 16, 0);
        run_line(32, 3); check_line("R10", 32, 16, 0, 16, 16, 16);
        run_line(32, 2); check_line("R10", 32, 16, 0, 16, 16, 16);

        tag = "R8";
        new_frame(20, 5, 10, 0);
        run_line(12, 0); check_line("R8", 12, 5, 0, 20, 5, 10);
        run_line(30, 0); check_line("R8", 30, 5, 0, 20, 5, 10);
        new_frame(20, 30, 10, 0);
        run_line(12, 0); check_line("R8", 12, 30, 0, 20, 30, 10);
        check("R8", "no hsync on unlaunched line", hs_at[0], -1);
        run_line(40, 0); check_line("R8", 40, 30, 0, 20, 30, 10);

        tag = "R11";
        new_frame(MAX_SEG, MAX_SEG, MAX_SEG, 0);
        run_line(2 * MAX_SEG, 0);
        check_line("R11", 2 * MAX_SEG, MAX_SEG, 0, MAX_SEG, MAX_SEG, MAX_SEG);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule